// File: doc/BRIEF.md
# Machine State Register Move Unit

This block computes the result of the three instructions that move data into and out of the 64-bit machine state register: a word move-to, a doubleword move-to and a move-from. It is purely combinational. Each cycle the execution pipeline presents an operation code, the L flag taken from the instruction, the current register value and the source operand. In the same cycle the block returns either the merged register value that the move-to would leave behind, or the read result that the move-from hands to a general register. Each result comes with its own valid flag. Privilege checks and instruction decode are done upstream and are not part of this block.

Bits are named by instruction-set number, with number 0 as the most significant bit, so number k sits at vector position 63-k. A move-to with L=0 copies a selected set of fields from the source and keeps every other bit. In that mode, source bit 49 (problem state) forces bits 48, 58 and 59 on. A doubleword move with L=0 also handles the three-bit field at bits 29 to 31 under a guard: the source value is taken except in one case, where the current value is kept. A move-to with L=1 changes only bits 48 and 62.

The ports are plain signals, not a valid/ready stream. The block has no state and nothing to stall, so the caller reads the outputs in the same cycle it presents the inputs. No back-pressure rules apply.

Top module: `msr_move_unit`

## Requirements
- R1: The op_sel encoding is 0 = idle, 1 = word move-to, 2 = doubleword move-to, 3 = move-from. When idle, both valid flags are 0, msr_out equals cur_msr and gpr_out is 0.
- R2: A move-from drives gpr_out with cur_msr and sets gpr_out_vld to 1. In that case msr_out_vld is 0 and msr_out equals cur_msr.
- R3: Both move-to operations set msr_out_vld to 1, hold gpr_out_vld at 0 and drive gpr_out to 0.
- R4: A word move-to with L=0 copies numbered bits 32-47, 49-50, 52-57 and 60-62 (vector position 63-k) from src_val.
- R5: A word move-to with L=0 keeps numbered bits 0-31, 51 and 63 at their cur_msr value.
- R6: For either move-to with L=0, each of numbered bits 48, 58 and 59 becomes the source bit OR source bit 49.
- R7: For either move-to with L=1, only numbered bits 48 and 62 are copied from src_val. Every other bit keeps its cur_msr value, and source bit 49 has no effect.
- R8: A doubleword move-to with L=0 copies numbered bits 0-2 and 4-28 from src_val, in addition to the ranges listed in R4.
- R9: For a doubleword move-to with L=0, the field at numbered bits 29-31 (bit 29 most significant) is normally taken from src_val. It keeps its cur_msr value when the current field is 010 and the source field is 000.
- R10: A doubleword move-to with L=0 keeps numbered bits 3, 51 and 63 at their cur_msr value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 2 | Operation code (R1 encoding) |
| l_flag | input | 1 | L flag from the instruction, used by move-to operations |
| cur_msr | input | 64 | Current machine state register value |
| src_val | input | 64 | Source operand register |
| msr_out | output | 64 | New machine state register value |
| msr_out_vld | output | 1 | msr_out should be written back |
| gpr_out | output | 64 | Read result for move-from |
| gpr_out_vld | output | 1 | gpr_out should be written back |

## Verification
The immediate assertions assume that every input is a known 0 or 1. Each assertion checks this first and skips the test while any input still carries X, which covers the time before the bench first drives its inputs. All four op_sel codes are legal, so the assertions place no limit on the operation. The bench drives only defined values, changes them one time unit after the rising edge and samples the outputs at the falling edge. Every vector, including the idle ones, is therefore settled and known when it is checked.

// File: rtl/msrmv_pkg.sv
package msrmv_pkg;
  localparam int REG_W = 64;
  localparam int FLD_W = 3;

  typedef enum logic [1:0] {
    MV_IDLE     = 2'd0,
    MV_TO_WORD  = 2'd1,
    MV_TO_DWORD = 2'd2,
    MV_FROM     = 2'd3
  } mv_op_e;

  // vector position of an instruction-set bit number (0 = MSB)
  function automatic int nb_pos(input int k);
    return REG_W - 1 - k;
  endfunction

  // mask covering numbered bits lo..hi inclusive
  function automatic logic [REG_W-1:0] nb_span(input int lo, input int hi);
    logic [REG_W-1:0] m;
    m = '0;
    for (int k = 0; k < REG_W; k++)
      if (k >= lo && k <= hi) m[REG_W-1-k] = 1'b1;
    return m;
  endfunction

  localparam int NB_PROB  = 49;
  localparam int NB_INTEN = 48;
  localparam int NB_IXLT  = 58;
  localparam int NB_DXLT  = 59;
  localparam int NB_RECOV = 62;
  localparam int NB_TRI_H = 29;
  localparam int NB_TRI_L = NB_TRI_H + FLD_W - 1;
endpackage

// File: rtl/msrmv_mask_decode.sv
module msrmv_mask_decode
  import msrmv_pkg::*;
(
  input  logic [1:0]       op_sel,
  input  logic             l_flag,
  output logic [REG_W-1:0] copy_mask,
  output logic [REG_W-1:0] or_mask,
  output logic             guard_en,
  output logic             write_en
);
  localparam logic [REG_W-1:0] WORD_COPY = nb_span(32, 47) | nb_span(49, 50) |
                                           nb_span(52, 57) | nb_span(60, 62);
  localparam logic [REG_W-1:0] DWORD_COPY = WORD_COPY | nb_span(0, 2) | nb_span(4, 28);
  localparam logic [REG_W-1:0] FORCE_BITS = nb_span(NB_INTEN, NB_INTEN) |
                                            nb_span(NB_IXLT, NB_DXLT);
  localparam logic [REG_W-1:0] NARROW_BITS = nb_span(NB_INTEN, NB_INTEN) |
                                             nb_span(NB_RECOV, NB_RECOV);

  always_comb begin
    copy_mask = '0;
    or_mask   = '0;
    guard_en  = 1'b0;
    write_en  = 1'b0;
    unique case (mv_op_e'(op_sel))
      MV_TO_WORD, MV_TO_DWORD: begin
        write_en = 1'b1;
        if (l_flag) begin
          copy_mask = NARROW_BITS;
        end else begin
          or_mask = FORCE_BITS;
          if (mv_op_e'(op_sel) == MV_TO_DWORD) begin
            copy_mask = DWORD_COPY;
            guard_en  = 1'b1;
          end else begin
            copy_mask = WORD_COPY;
          end
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_sel, l_flag})) begin
      assert_masks_disjoint_R6: assert ((copy_mask & or_mask) == '0)
        else $error("copy and override masks overlap");
      assert_guard_dword_only_R9: assert (!guard_en || (op_sel == 2'd2 && !l_flag))
        else $error("field guard enabled outside doubleword L=0");
      assert_narrow_no_force_R7: assert (!(write_en && l_flag) || or_mask == '0)
        else $error("override active with L=1");
    end
  end
endmodule

// File: rtl/msrmv_ps_override.sv
module msrmv_ps_override
  import msrmv_pkg::*;
(
  input  logic [REG_W-1:0] src_val,
  input  logic [REG_W-1:0] or_mask,
  output logic [REG_W-1:0] ovr_bits
);
  logic ps;
  assign ps = src_val[nb_pos(NB_PROB)];

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    assign ovr_bits[i] = or_mask[i] & (src_val[i] | ps);
  end

  always_comb begin
    if (!$isunknown({src_val, or_mask})) begin
      assert_ps_forces_R6: assert (!ps || ((ovr_bits & or_mask) == or_mask))
        else $error("problem-state did not force controlled bits");
      assert_ovr_confined_R6: assert ((ovr_bits & ~or_mask) == '0)
        else $error("override leaked outside its mask");
    end
  end
endmodule

// File: rtl/msrmv_field_guard.sv
module msrmv_field_guard #(
  parameter int W = 3,
  parameter logic [W-1:0] KEEP_CUR = 3'b010
) (
  input  logic         en,
  input  logic [W-1:0] cur_f,
  input  logic [W-1:0] src_f,
  output logic [W-1:0] new_f,
  output logic         take
);
  logic hold;
  assign hold  = (cur_f == KEEP_CUR) && (src_f == '0);
  assign take  = en && !hold;
  assign new_f = take ? src_f : cur_f;

  always_comb begin
    if (!$isunknown({en, cur_f, src_f})) begin
      assert_guard_hold_R9: assert (!(en && cur_f == KEEP_CUR && src_f == '0) || new_f == cur_f)
        else $error("guarded field changed in hold case");
      assert_guard_take_R9: assert (!(en && (cur_f != KEEP_CUR || src_f != '0)) || new_f == src_f)
        else $error("guarded field not taken from source");
    end
  end
endmodule

// File: rtl/msr_move_unit.sv
module msr_move_unit
  import msrmv_pkg::*;
(
  input  logic [1:0]  op_sel,
  input  logic        l_flag,
  input  logic [63:0] cur_msr,
  input  logic [63:0] src_val,
  output logic [63:0] msr_out,
  output logic        msr_out_vld,
  output logic [63:0] gpr_out,
  output logic        gpr_out_vld
);
  localparam int FLD_LO = nb_pos(NB_TRI_L);
  localparam logic [REG_W-1:0] FLD_MASK = nb_span(NB_TRI_H, NB_TRI_L);
  localparam logic [REG_W-1:0] KEEP_DW  = nb_span(3, 3) | nb_span(51, 51) | nb_span(63, 63);
  localparam logic [REG_W-1:0] CHG_L1   = nb_span(48, 48) | nb_span(62, 62);

  logic [REG_W-1:0] copy_mask, or_mask, ovr_bits, fld_mask, fld_bits;
  logic             guard_en, write_en, fld_take;
  logic [FLD_W-1:0] fld_new;

  msrmv_mask_decode u_dec (
    .op_sel   (op_sel),
    .l_flag   (l_flag),
    .copy_mask(copy_mask),
    .or_mask  (or_mask),
    .guard_en (guard_en),
    .write_en (write_en)
  );

  msrmv_ps_override u_ovr (
    .src_val (src_val),
    .or_mask (or_mask),
    .ovr_bits(ovr_bits)
  );

  msrmv_field_guard #(.W(FLD_W), .KEEP_CUR(3'b010)) u_fld (
    .en   (guard_en),
    .cur_f(cur_msr[FLD_LO +: FLD_W]),
    .src_f(src_val[FLD_LO +: FLD_W]),
    .new_f(fld_new),
    .take (fld_take)
  );

  assign fld_mask = guard_en ? FLD_MASK : '0;

  for (genvar i = 0; i < REG_W; i++) begin : g_fld
    if (i >= FLD_LO && i < FLD_LO + FLD_W) begin : g_in
      assign fld_bits[i] = fld_new[i - FLD_LO];
    end else begin : g_out
      assign fld_bits[i] = 1'b0;
    end
  end

  assign msr_out = (cur_msr & ~(copy_mask | or_mask | fld_mask)) |
                   (src_val & copy_mask) | ovr_bits | (fld_bits & fld_mask);
  assign msr_out_vld = write_en;
  assign gpr_out_vld = (mv_op_e'(op_sel) == MV_FROM);
  assign gpr_out     = gpr_out_vld ? cur_msr : '0;

  always_comb begin
    if (!$isunknown({op_sel, l_flag, cur_msr, src_val})) begin
      assert_one_result_R3: assert ($onehot0({msr_out_vld, gpr_out_vld}))
        else $error("both results valid");
      assert_idle_keeps_R1: assert (msr_out_vld || msr_out == cur_msr)
        else $error("msr changed without write");
      assert_read_value_R2: assert (!gpr_out_vld || gpr_out == cur_msr)
        else $error("read result differs from msr");
      assert_narrow_only_R7: assert (!(msr_out_vld && l_flag) ||
                                     ((msr_out ^ cur_msr) & ~CHG_L1) == '0)
        else $error("L=1 move changed other bits");
      assert_dword_keep_R10: assert (!(op_sel == 2'd2 && !l_flag) ||
                                     ((msr_out ^ cur_msr) & KEEP_DW) == '0)
        else $error("doubleword move changed retained bits");
      assert_field_take_R9: assert (!fld_take || msr_out[FLD_LO +: FLD_W] == src_val[FLD_LO +: FLD_W])
        else $error("guarded field mismatch");
    end
  end
endmodule

// File: tb/msr_move_unit_tb.sv
module msr_move_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]  op_sel = 2'd0;
  logic        l_flag = 1'b0;
  logic [63:0] cur_msr = '0, src_val = '0;
  logic [63:0] msr_out, gpr_out;
  logic        msr_out_vld, gpr_out_vld;

  msr_move_unit u_dut (
    .op_sel(op_sel), .l_flag(l_flag), .cur_msr(cur_msr), .src_val(src_val),
    .msr_out(msr_out), .msr_out_vld(msr_out_vld),
    .gpr_out(gpr_out), .gpr_out_vld(gpr_out_vld)
  );

  typedef struct {
    logic [63:0] e_msr;
    logic        e_mv;
    logic [63:0] e_gpr;
    logic        e_gv;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_bad = 0;
  bit drv_done = 0;

  function automatic bit in_r(int k, int lo, int hi);
    return k >= lo && k <= hi;
  endfunction

  function automatic logic [63:0] model(logic [1:0] op, logic l, logic [63:0] c, logic [63:0] s);
    logic [63:0] n;
    logic ps;
    logic [2:0] cf, sf;
    n = c;
    ps = s[63-49];
    if (op == 2'd1 || op == 2'd2) begin
      for (int k = 0; k < 64; k++) begin
        if (l) begin
          if (k == 48 || k == 62) n[63-k] = s[63-k];
        end else if (k == 48 || k == 58 || k == 59) begin
          n[63-k] = s[63-k] | ps;
        end else if (in_r(k,32,47) || in_r(k,49,50) || in_r(k,52,57) || in_r(k,60,62)) begin
          n[63-k] = s[63-k];
        end else if (op == 2'd2 && (in_r(k,0,2) || in_r(k,4,28))) begin
          n[63-k] = s[63-k];
        end
      end
      if (op == 2'd2 && !l) begin
        cf = {c[63-29], c[63-30], c[63-31]};
        sf = {s[63-29], s[63-30], s[63-31]};
        if (!(cf == 3'b010 && sf == 3'b000)) begin
          n[63-29] = sf[2]; n[63-30] = sf[1]; n[63-31] = sf[0];
        end
      end
    end
    return n;
  endfunction

  task automatic apply(logic [1:0] op, logic l, logic [63:0] c, logic [63:0] s, string tag);
    exp_t e;
    @(posedge clk);
    #1;
    op_sel = op; l_flag = l; cur_msr = c; src_val = s;
    e.e_msr = model(op, l, c, s);
    e.e_mv  = (op == 2'd1 || op == 2'd2);
    e.e_gv  = (op == 2'd3);
    e.e_gpr = (op == 2'd3) ? c : 64'd0;
    e.tag   = tag;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (msr_out !== e.e_msr || msr_out_vld !== e.e_mv ||
          gpr_out !== e.e_gpr || gpr_out_vld !== e.e_gv) begin
        n_bad++;
        $display("FAIL %s msr=%h/%b gpr=%h/%b expected msr=%h/%b gpr=%h/%b", e.tag,
                 msr_out, msr_out_vld, gpr_out, gpr_out_vld,
                 e.e_msr, e.e_mv, e.e_gpr, e.e_gv);
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  localparam logic [63:0] B49 = 64'd1 << 14;
  localparam logic [63:0] F010 = 64'd1 << 33;
  localparam logic [63:0] F001 = 64'd1 << 32;
  localparam logic [63:0] F011 = (64'd1 << 33) | (64'd1 << 32);

  initial begin
    logic [63:0] lf;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    apply(2'd0, 1'b0, 64'h0123_4567_89ab_cdef, 64'hffff_0000_ffff_0000, "R1 idle");
    apply(2'd0, 1'b1, '1, '1, "R1 idle L=1");
    apply(2'd3, 1'b0, 64'hdead_beef_cafe_f00d, 64'h1111, "R2 move-from");
    apply(2'd3, 1'b1, '1, '0, "R2 move-from all ones");
    apply(2'd1, 1'b0, '0, '1 & ~B49, "R4 R3 word copy ranges");
    apply(2'd1, 1'b0, '1, '0, "R5 word keeps upper half");
    apply(2'd1, 1'b0, '0, B49, "R6 word problem-state force");
    apply(2'd2, 1'b0, '0, B49, "R6 dword problem-state force");
    apply(2'd1, 1'b1, '0, '1, "R7 word L=1");
    apply(2'd2, 1'b1, '1, B49, "R7 dword L=1 ps ignored");
    apply(2'd2, 1'b0, '0, '1 & ~B49, "R8 dword copy ranges");
    apply(2'd2, 1'b0, F010, 64'h0, "R9 guard hold 010/000");
    apply(2'd2, 1'b0, F010, F001, "R9 guard take src 001");
    apply(2'd2, 1'b0, F011, 64'h0, "R9 guard take src 000");
    apply(2'd2, 1'b0, '1, '0, "R10 dword keeps 3 51 63");
    lf = 64'h9e37_79b9_7f4a_7c15;
    for (int i = 0; i < 64; i++) begin
      logic [63:0] a;
      a = lf;
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      lf = lf ^ (lf << 13) ^ (lf >> 7);
      apply(a[1:0], a[2], a, lf, "R3 R6 mixed pseudo-random");
    end
    drv_done = 1;
    @(posedge clk);
    wait (sb.size() == 0);
    @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule